// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on into a programmed state before the memory controller starts normal traffic. After reset it waits for a start request. Once the request is accepted, it holds the command lines at no-operation for a power-on settling period whose length is a design parameter. It then issues a precharge of every bank, eight auto-refresh commands and one mode-register load. A programmable number of idle cycles separates each command from the next.

Two 2-bit configuration codes set the idle gaps. One sets the gap after the precharge. The other sets the gap after each refresh, including the gap that comes before the mode-register load. The mode value is driven onto the low address bits during the mode-register load. The codes and the mode value are captured in the cycle the start request is accepted. After the mode-register load at least one idle cycle follows, and then a done flag rises and stays high until the next reset. The data bus is never driven.

Top module: `sdram_init_seq`

## Requirements
- R1: While in reset and until a start request is accepted, the command lines carry NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), addr_o is all zero and done_o is low.
- R2: A start request is accepted only before the first sequence; start_i pulses during a running sequence or after done_o has risen change no output.
- R3: The first cycle after the accepting clock edge begins a window of PWR_CYCLES NOP cycles, and the precharge comes in the cycle right after that window.
- R4: The precharge-all command is a single cycle with pins 0,0,1,0, addr_o bit AP_BIT (default 10) high and all other address bits low.
- R5: The precharge is followed by trp_code+1 NOP cycles (codes 0..3 give 1..4) and then the first refresh.
- R6: Exactly eight refresh commands (pins 0,0,0,1) are issued, one cycle each, and each is followed by trc_code+1 NOP cycles, including the eighth.
- R7: The mode-register load (pins 0,0,0,0) comes right after the eighth refresh gap, with mode_val_i in addr_o[MODE_W-1:0] and zeros above that.
- R8: The mode-register load is followed by MRS_GAP (at least 1) NOP cycles. done_o then rises in the next cycle and stays high with NOP on the lines until reset.
- R9: dq_oe_o stays low in every cycle, so the data bus stays at high impedance.
- R10: trp_code_i, trc_code_i and mode_val_i are sampled when start is accepted; changing them later does not alter the running sequence.
- R11: Every command is followed by at least one NOP cycle, and addr_o is zero in all NOP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin initialization |
| trp_code_i | input | 2 | Idle-gap code after precharge (n gives n+1 cycles) |
| trc_code_i | input | 2 | Idle-gap code after each refresh (n gives n+1 cycles) |
| mode_val_i | input | MODE_W | Value written to the mode register |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | SDRAM address bus |
| dq_oe_o | output | 1 | Data bus output enable (always low) |
| done_o | output | 1 | Initialization finished, sticky until reset |

## Verification
The bench drives the extreme gap codes 0 and 3 in every combination, then random codes and mode values, and compares every cycle with a timeline computed from the requirements. If the gap count were off by one, the first refresh or the mode load would land a cycle early or late. If the refresh counter were wrong, the bench would see seven or nine refreshes, or the mode load would come without its gap. In some trials the configuration inputs are changed, or start is pulsed again, while the sequence is running. A design that does not capture its inputs at start, or that lets a second start restart the sequence, would then stretch or repeat the sequence, or drop done_o.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR,
        S_PALL,
        S_GAP_P,
        S_REF,
        S_GAP_R,
        S_MRS,
        S_GAP_M,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_NOP  = cmd_pins_t'(4'b0111);
    localparam cmd_pins_t CMD_PALL = cmd_pins_t'(4'b0010);
    localparam cmd_pins_t CMD_REF  = cmd_pins_t'(4'b0001);
    localparam cmd_pins_t CMD_MRS  = cmd_pins_t'(4'b0000);

    localparam int REF_TOTAL = 8;

endpackage

// File: rtl/sdinit_gap_timer.sv
module sdinit_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R3: an expired timer stays expired until it is reloaded
    p_hold_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && zero_o) |=> zero_o);

    // R5: a timer that is counting moves down by exactly one per cycle
    p_step_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdinit_ref_counter.sv
module sdinit_ref_counter #(
    parameter int N = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clr_i,
    input  logic                 inc_i,
    output logic [$clog2(N)-1:0] cnt_o,
    output logic                 last_o
);

    localparam int W = $clog2(N);
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == LAST);

    // R6: the count never steps past the last refresh
    p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(inc_i && last_o));

endmodule

// File: rtl/sdinit_cmd_enc.sv
module sdinit_cmd_enc
    import sdinit_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int MODE_W = 12
) (
    input  seq_state_e        state_i,
    input  logic [MODE_W-1:0] mode_i,
    output cmd_pins_t         cmd_o,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        cmd_o  = CMD_NOP;
        addr_o = '0;
        case (state_i)
            S_PALL: begin
                cmd_o          = CMD_PALL;
                addr_o[AP_BIT] = 1'b1;
            end
            S_REF: begin
                cmd_o = CMD_REF;
            end
            S_MRS: begin
                cmd_o  = CMD_MRS;
                addr_o = ADDR_W'(mode_i);
            end
            default: begin
                cmd_o  = CMD_NOP;
                addr_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int PWR_CYCLES = 20000,
    parameter int MRS_GAP    = 1,
    parameter int ADDR_W     = 13,
    parameter int AP_BIT     = 10,
    parameter int MODE_W     = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        trp_code_i,
    input  logic [1:0]        trc_code_i,
    input  logic [MODE_W-1:0] mode_val_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              dq_oe_o,
    output logic              done_o
);

    localparam int PWR_W  = $clog2(PWR_CYCLES + 1);
    localparam int GAP_W  = $clog2(MRS_GAP + 1);
    localparam int TMR_W0 = (PWR_W > 2) ? PWR_W : 2;
    localparam int TMR_W  = (GAP_W > TMR_W0) ? GAP_W : TMR_W0;
    localparam int REF_W  = $clog2(REF_TOTAL);

    localparam logic [TMR_W-1:0] PWR_LOAD  = (PWR_CYCLES > 0) ? TMR_W'(PWR_CYCLES - 1) : '0;
    localparam logic [TMR_W-1:0] MRS_LOAD  = (MRS_GAP > 1) ? TMR_W'(MRS_GAP - 1) : '0;
    localparam logic [REF_W-1:0] REF_LASTV = REF_W'(REF_TOTAL - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [1:0]        trp;
        logic [1:0]        trc;
        logic [MODE_W-1:0] mode;
    } seq_regs_t;

    seq_regs_t        seq_d, seq_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             ref_clr;
    logic             ref_inc;
    logic [REF_W-1:0] ref_cnt;
    logic             ref_last;
    cmd_pins_t        cmd;

    // ---------------- next-state logic ----------------
    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_clr  = 1'b0;
        ref_inc  = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (start_i) begin
                    seq_d.trp  = trp_code_i;
                    seq_d.trc  = trc_code_i;
                    seq_d.mode = mode_val_i;
                    ref_clr    = 1'b1;
                    if (PWR_CYCLES == 0) begin
                        seq_d.st = S_PALL;
                    end else begin
                        seq_d.st = S_PWR;
                        tmr_load = 1'b1;
                        tmr_val  = PWR_LOAD;
                    end
                end
            end
            S_PWR: begin
                if (tmr_zero) seq_d.st = S_PALL;
            end
            S_PALL: begin
                seq_d.st = S_GAP_P;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(seq_q.trp);
            end
            S_GAP_P: begin
                if (tmr_zero) seq_d.st = S_REF;
            end
            S_REF: begin
                seq_d.st = S_GAP_R;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(seq_q.trc);
            end
            S_GAP_R: begin
                if (tmr_zero) begin
                    if (ref_last) begin
                        seq_d.st = S_MRS;
                    end else begin
                        seq_d.st = S_REF;
                        ref_inc  = 1'b1;
                    end
                end
            end
            S_MRS: begin
                seq_d.st = S_GAP_M;
                tmr_load = 1'b1;
                tmr_val  = MRS_LOAD;
            end
            S_GAP_M: begin
                if (tmr_zero) seq_d.st = S_DONE;
            end
            S_DONE: begin
                seq_d.st = S_DONE;
            end
            default: begin
                seq_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: S_IDLE, trp: 2'd0, trc: 2'd0, mode: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // ---------------- sub-blocks ----------------
    sdinit_gap_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    sdinit_ref_counter #(
        .N (REF_TOTAL)
    ) u_refcnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ref_clr),
        .inc_i  (ref_inc),
        .cnt_o  (ref_cnt),
        .last_o (ref_last)
    );

    sdinit_cmd_enc #(
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT),
        .MODE_W (MODE_W)
    ) u_enc (
        .state_i (seq_q.st),
        .mode_i  (seq_q.mode),
        .cmd_o   (cmd),
        .addr_o  (addr_o)
    );

    assign cs_n_o  = cmd.cs_n;
    assign ras_n_o = cmd.ras_n;
    assign cas_n_o = cmd.cas_n;
    assign we_n_o  = cmd.we_n;
    assign dq_oe_o = 1'b0;
    assign done_o  = (seq_q.st == S_DONE);

    // ---------------- assertions ----------------
    // R11: every command is followed by a NOP cycle
    p_nop_after_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R4: precharge-all drives the all-banks address bit
    p_pall_ap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd == CMD_PALL) |-> addr_o[AP_BIT]);

    // R6: the mode load is reached only after the eighth refresh
    p_mrs_after_eighth_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == S_MRS) |-> (ref_cnt == REF_LASTV));

    // R8: done is sticky and the lines stay idle
    p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (done_o && cmd == CMD_NOP));

    // R2: once started, the sequencer never returns to accept another start
    p_no_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st != S_IDLE) |=> (seq_q.st != S_IDLE));

    // R10: captured configuration is frozen while a sequence runs
    p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st != S_IDLE) |=> ($stable(seq_q.trp) && $stable(seq_q.trc) && $stable(seq_q.mode)));

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

    localparam int PWR  = 20;
    localparam int GAPM = 1;
    localparam int AW   = 13;
    localparam int AP   = 10;
    localparam int MW   = 12;

    localparam logic [3:0] E_NOP  = 4'b0111;
    localparam logic [3:0] E_PALL = 4'b0010;
    localparam logic [3:0] E_REF  = 4'b0001;
    localparam logic [3:0] E_MRS  = 4'b0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    trp = 2'd0;
    logic [1:0]    trc = 2'd0;
    logic [MW-1:0] mode = '0;
    logic          cs_n, ras_n, cas_n, we_n, dq_oe, done;
    logic [AW-1:0] addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .PWR_CYCLES (PWR),
        .MRS_GAP    (GAPM),
        .ADDR_W     (AW),
        .AP_BIT     (AP),
        .MODE_W     (MW)
    ) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .trp_code_i (trp),
        .trc_code_i (trc),
        .mode_val_i (mode),
        .cs_n_o     (cs_n),
        .ras_n_o    (ras_n),
        .cas_n_o    (cas_n),
        .we_n_o     (we_n),
        .addr_o     (addr),
        .dq_oe_o    (dq_oe),
        .done_o     (done)
    );

    function automatic int ref0_t(int p);
        return PWR + 1 + p + 1;
    endfunction

    function automatic int mrs_t(int p, int c);
        return ref0_t(p) + 8 * (c + 2);
    endfunction

    function automatic int done_t(int p, int c);
        return mrs_t(p, c) + 1 + GAPM;
    endfunction

    function automatic logic [3:0] exp_cmd(int t, int p, int c);
        if (t == PWR) return E_PALL;
        for (int k = 0; k < 8; k++) begin
            if (t == ref0_t(p) + k * (c + 2)) return E_REF;
        end
        if (t == mrs_t(p, c)) return E_MRS;
        return E_NOP;
    endfunction

    function automatic logic [AW-1:0] exp_addr(int t, int p, int c, logic [MW-1:0] m);
        logic [AW-1:0] a;
        a = '0;
        if (t == PWR) a[AP] = 1'b1;
        else if (t == mrs_t(p, c)) a = AW'(m);
        return a;
    endfunction

    function automatic string tag_of(int t, int p, int c);
        if (t < PWR) return "R3";
        if (t == PWR) return "R4";
        if (t < ref0_t(p)) return "R5";
        if (t < mrs_t(p, c)) return "R6";
        if (t == mrs_t(p, c)) return "R7";
        return "R8";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(string req);
        chk({req, " cmd"}, 32'({cs_n, ras_n, cas_n, we_n}), 32'(E_NOP));
        chk({req, " addr"}, 32'(addr), 32'd0);
        chk({req, " done"}, 32'(done), 32'd0);
        chk("R9 dq_oe", 32'(dq_oe), 32'd0);
    endtask

    task automatic run_trial(int p, int c, logic [MW-1:0] m, bit glitch, bit change);
        int td;
        string tg;
        start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 in-reset");
        rst_n = 1'b1;
        repeat ($urandom_range(1, 5)) begin
            @(negedge clk);
            check_idle("R1 pre-start");
        end
        trp   = 2'(p);
        trc   = 2'(c);
        mode  = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        td = done_t(p, c);
        for (int t = 0; t <= td + 3; t++) begin
            tg = tag_of(t, p, c);
            if (change) tg = {tg, " R10"};
            if (glitch) tg = {tg, " R2"};
            chk({tg, " cmd"}, 32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_cmd(t, p, c)));
            chk({tg, " R11 addr"}, 32'(addr), 32'(exp_addr(t, p, c, m)));
            chk({tg, " done"}, 32'(done), 32'(t >= td));
            chk("R9 dq_oe", 32'(dq_oe), 32'd0);
            if (change) begin
                trp  = 2'($urandom);
                trc  = 2'($urandom);
                mode = MW'($urandom);
            end
            if (glitch) start = 1'($urandom);
            @(negedge clk);
        end
        // R2: start after done has no effect
        start = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R2 post-done cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(E_NOP));
            chk("R2 post-done done", 32'(done), 32'd1);
            chk("R2 post-done addr", 32'(addr), 32'd0);
        end
        start = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        run_trial(0, 0, 12'hFFF, 1'b0, 1'b0);
        run_trial(3, 3, 12'h000, 1'b0, 1'b0);
        run_trial(0, 3, 12'hA5A, 1'b1, 1'b0);
        run_trial(3, 0, 12'h5A5, 1'b0, 1'b1);
        for (int n = 0; n < 24; n++) begin
            run_trial(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                      MW'($urandom), 1'($urandom), 1'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule